// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns the addressing part of an instruction into something the execute stage can use. Given a 3-bit mode code, a register-direct flag, the value read from the register file, the program counter and the instruction's constant field, it returns one of two things. It returns either the operand itself or the effective address where the operand lives, together with a flag telling which of the two it is. In the modes that step a pointer register, it also issues a one-cycle register write-back request carrying the new pointer value.

Most modes finish in one clock: a request accepted on one rising edge produces its result pulse right after that edge. The memory-indirect mode needs the pointer word from memory first. The block raises a read request at the address given by the constant field, holds it until the memory answers with ready, and then reports the returned word as the effective address. While that read is outstanding, the block is busy and new requests are not taken.

The constant field is extended to the address width, by sign extension or zero extension as a parameter selects. All address arithmetic wraps modulo 2^AW. The pointer step is 4 bytes for word operands and 1 byte for byte operands.

Top module: `ea_unit`

## Requirements
- R1: After reset, `busy`, `done`, `wb_en` and `mem_rd_req` are all 0.
- R2: When `reg_direct` is 1, the request returns `reg_val` as an operand (`is_addr`=0) whatever `mode` holds, with no write-back and no memory read.
- R3: Absolute mode (`mode`=0) returns the sign-extended 16-bit `konst` as the effective address (`is_addr`=1).
- R4: Immediate mode (`mode`=1) returns the sign-extended `konst` as the operand (`is_addr`=0).
- R5: Register-indirect mode (`mode`=2) returns `reg_val` as the effective address.
- R6: Indexed mode (`mode`=4) returns `reg_val` plus the sign-extended `konst`, modulo 2^32, as the effective address.
- R7: Relative mode (`mode`=5) returns `pc` plus the sign-extended `konst`, modulo 2^32, as the effective address.
- R8: Autoincrement mode (`mode`=6) returns `reg_val` as the effective address and writes back `reg_val` plus the step. The step is 4 when `size_word`=1 and 1 otherwise.
- R9: Autodecrement mode (`mode`=7) returns `reg_val` minus the step as the effective address and writes back that same decremented value.
- R10: `wb_en` is high only in the cycle in which `done` is high for an autoincrement or autodecrement request, never otherwise.
- R11: Memory-indirect mode (`mode`=3):
  - `mem_rd_req` rises one cycle after the request is accepted.
  - `mem_rd_addr` is the sign-extended `konst`, and both the request and the address hold steady until `mem_rd_ready` is sampled high.
  - In the following cycle, `done` is high with `result` equal to the `mem_rd_data` sampled with ready, and `is_addr`=1.
- R12: While `busy` is 1, `start` is ignored. A `mem_rd_ready` that arrives with no read outstanding produces no result.
- R13: For every mode other than memory-indirect, `done` is high for exactly the one cycle after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when not busy |
| reg_direct | input | 1 | Register-direct operand: return the register value |
| mode | input | 3 | Addressing mode code |
| size_word | input | 1 | 1: word operand (step 4), 0: byte operand (step 1) |
| reg_val | input | 32 | Contents of the selected register |
| pc | input | 32 | Program counter |
| konst | input | 16 | Instruction constant field |
| mem_rd_ready | input | 1 | Memory answers the pointer read |
| mem_rd_data | input | 32 | Pointer word from memory |
| busy | output | 1 | Pointer read outstanding |
| done | output | 1 | Result valid pulse |
| result | output | 32 | Operand value or effective address |
| is_addr | output | 1 | 1 when `result` is an effective address |
| wb_en | output | 1 | Register write-back strobe |
| wb_data | output | 32 | Updated pointer register value |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | 32 | Pointer read address |

## Verification
The hardest situation to reach is a new `start`, or a stray `mem_rd_ready`, arriving while a pointer read is still in flight or after it has been closed. Each of these could produce a second result or overwrite the first.

The bench's memory responder has a programmable latency, so a several-cycle wait can be opened on purpose. During that wait, the driver fires a conflicting absolute-mode request. Once the block is idle again, it injects a lone ready pulse.

The scoreboard counts every `done` against what was queued. Any extra result, or a result on the wrong cycle, is therefore reported.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      AM_ABS  = 3'd0,
      AM_IMM  = 3'd1,
      AM_RIND = 3'd2,
      AM_MIND = 3'd3,
      AM_IDX  = 3'd4,
      AM_REL  = 3'd5,
      AM_AINC = 3'd6,
      AM_ADEC = 3'd7
   } am_e;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fetch_state_e;

endpackage

// File: rtl/ea_const_ext.sv
module ea_const_ext #(
   parameter int CW       = 16,
   parameter int AW       = 32,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [CW-1:0] k_in,
   output logic [AW-1:0] k_ext
);
   localparam int PADW = AW - CW;

   generate
      if (CW >= AW) begin : g_bad
         $error("ea_const_ext: constant width must be below address width");
      end
      if (SIGN_EXT) begin : g_sext
         assign k_ext = {{PADW{k_in[CW-1]}}, k_in};
      end else begin : g_zext
         assign k_ext = {{PADW{1'b0}}, k_in};
      end
   endgenerate
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
   import ea_pkg::*;
#(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic          reg_direct,
   input  am_e           mode,
   input  logic          size_word,
   input  logic [AW-1:0] reg_val,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] k_ext,
   output logic [AW-1:0] res,
   output logic          res_is_addr,
   output logic          res_wb,
   output logic [AW-1:0] res_wb_data,
   output logic          need_mem
);
   localparam logic [AW-1:0] STEP_W = AW'(WORD_BYTES);
   localparam logic [AW-1:0] STEP_B = AW'(1);

   generate
      if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_wb
         $error("ea_addr_calc: WORD_BYTES must be a power of two above one");
      end
   endgenerate

   logic [AW-1:0] step;
   logic [AW-1:0] base;
   logic [AW-1:0] sum;
   logic [AW-1:0] ptr_inc;
   logic [AW-1:0] ptr_dec;

   assign step    = size_word ? STEP_W : STEP_B;
   // relative mode shares the index adder, with the PC as the base
   assign base    = (mode == AM_REL) ? pc : reg_val;
   assign sum     = base + k_ext;
   assign ptr_inc = reg_val + step;
   assign ptr_dec = reg_val - step;

   always_comb begin
      res         = reg_val;
      res_is_addr = 1'b1;
      res_wb      = 1'b0;
      res_wb_data = ptr_inc;
      need_mem    = 1'b0;
      if (reg_direct) begin
         res_is_addr = 1'b0;
      end else begin
         unique case (mode)
            AM_ABS:  res = k_ext;
            AM_IMM: begin
               res         = k_ext;
               res_is_addr = 1'b0;
            end
            AM_RIND: res = reg_val;
            AM_MIND: need_mem = 1'b1;
            AM_IDX,
            AM_REL:  res = sum;
            AM_AINC: begin
               res         = reg_val;
               res_wb      = 1'b1;
               res_wb_data = ptr_inc;
            end
            AM_ADEC: begin
               res         = ptr_dec;
               res_wb      = 1'b1;
               res_wb_data = ptr_dec;
            end
            default: res = reg_val;
         endcase
      end
   end
endmodule

// File: rtl/ea_ind_fetch.sv
module ea_ind_fetch
   import ea_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] ptr_addr,
   input  logic          rd_ready,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   output logic          fin,
   output logic          busy
);
   fetch_state_e st;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FS_IDLE;
         addr_q <= '0;
      end else begin
         unique case (st)
            FS_IDLE: if (launch) begin
               st     <= FS_WAIT;
               addr_q <= ptr_addr;
            end
            FS_WAIT: if (rd_ready) st <= FS_IDLE;
            default: st <= FS_IDLE;
         endcase
      end
   end

   assign rd_req  = (st == FS_WAIT);
   assign rd_addr = addr_q;
   assign busy    = (st == FS_WAIT);
   assign fin     = (st == FS_WAIT) && rd_ready;

   // R11: request and address hold until ready
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ready |=> rd_req && $stable(rd_addr));
   // R11: request drops after the handshake
   a_r11_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_ready |=> !rd_req);
   // R11: a launch opens a request on the next cycle
   a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
      launch && !busy |=> rd_req && rd_addr == $past(ptr_addr));
endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 16,
   parameter int WORD_BYTES = 4,
   parameter bit SIGN_EXT   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          reg_direct,
   input  logic [2:0]    mode,
   input  logic          size_word,
   input  logic [AW-1:0] reg_val,
   input  logic [AW-1:0] pc,
   input  logic [CW-1:0] konst,
   input  logic          mem_rd_ready,
   input  logic [AW-1:0] mem_rd_data,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] result,
   output logic          is_addr,
   output logic          wb_en,
   output logic [AW-1:0] wb_data,
   output logic          mem_rd_req,
   output logic [AW-1:0] mem_rd_addr
);
   generate
      if (AW < 16) begin : g_bad_aw
         $error("ea_unit: address width too small");
      end
   endgenerate

   am_e           mode_e;
   logic [AW-1:0] k_ext;
   logic [AW-1:0] c_res;
   logic          c_is_addr;
   logic          c_wb;
   logic [AW-1:0] c_wb_data;
   logic          c_need_mem;
   logic          accept;
   logic          fetch_fin;
   logic          fetch_busy;

   assign mode_e = am_e'(mode);
   assign accept = start && !fetch_busy;
   assign busy   = fetch_busy;

   ea_const_ext #(.CW(CW), .AW(AW), .SIGN_EXT(SIGN_EXT)) u_ext (
      .k_in  (konst),
      .k_ext (k_ext)
   );

   ea_addr_calc #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_calc (
      .reg_direct  (reg_direct),
      .mode        (mode_e),
      .size_word   (size_word),
      .reg_val     (reg_val),
      .pc          (pc),
      .k_ext       (k_ext),
      .res         (c_res),
      .res_is_addr (c_is_addr),
      .res_wb      (c_wb),
      .res_wb_data (c_wb_data),
      .need_mem    (c_need_mem)
   );

   ea_ind_fetch #(.AW(AW)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (accept && c_need_mem),
      .ptr_addr (k_ext),
      .rd_ready (mem_rd_ready),
      .rd_req   (mem_rd_req),
      .rd_addr  (mem_rd_addr),
      .fin      (fetch_fin),
      .busy     (fetch_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         result  <= '0;
         is_addr <= 1'b0;
         wb_en   <= 1'b0;
         wb_data <= '0;
      end else if (fetch_fin) begin
         done    <= 1'b1;
         result  <= mem_rd_data;
         is_addr <= 1'b1;
         wb_en   <= 1'b0;
      end else if (accept && !c_need_mem) begin
         done    <= 1'b1;
         result  <= c_res;
         is_addr <= c_is_addr;
         wb_en   <= c_wb;
         wb_data <= c_wb_data;
      end else begin
         done  <= 1'b0;
         wb_en <= 1'b0;
      end
   end

   // R10: write-back only together with a result that is an address
   a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done && is_addr);
   // R10: pointer update differs from the result by zero or one step
   a_r10_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_data == result) || (wb_data - result == AW'(1))
                || (wb_data - result == AW'(WORD_BYTES)));
   // R11: the fetched word is reported the cycle after ready
   a_r11_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && mem_rd_ready |=> done && is_addr && result == $past(mem_rd_data));
   // R13: single-cycle modes report on the next cycle
   a_r13_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (reg_direct || mode != 3'd3) |=> done);
   // R2: register-direct requests return an operand with no write-back
   a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && reg_direct |=> !is_addr && !wb_en && !mem_rd_req);
   // R12: ready with no outstanding read yields no result
   a_r12_stray_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_ready && !mem_rd_req && !start |=> !done);
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
   localparam int AW = 32;

   typedef struct {
      string       tag;
      logic [31:0] res;
      logic        ia;
      logic        we;
      logic [31:0] wd;
      int          due;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        reg_direct = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        size_word = 1'b0;
   logic [31:0] reg_val = '0;
   logic [31:0] pc = '0;
   logic [15:0] konst = '0;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        busy, done, is_addr, wb_en, mem_rd_req;
   logic [31:0] result, wb_data, mem_rd_addr;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int lat = 0;
   int wait_cnt = 0;
   bit stray = 1'b0;
   bit prev_ready = 1'b0;
   logic [31:0] exp_ptr = '0;
   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ea_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_direct(reg_direct),
      .mode(mode), .size_word(size_word), .reg_val(reg_val), .pc(pc),
      .konst(konst), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
      .busy(busy), .done(done), .result(result), .is_addr(is_addr),
      .wb_en(wb_en), .wb_data(wb_data), .mem_rd_req(mem_rd_req),
      .mem_rd_addr(mem_rd_addr)
   );

   function automatic logic [31:0] sx(input logic [15:0] k);
      return {{16{k[15]}}, k};
   endfunction

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
   endfunction

   task automatic check(input string tag, input bit ok, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // driver: builds the expectation from the requirements and issues it
   task automatic issue(input bit rd, input logic [2:0] m, input bit sz,
                        input logic [31:0] rv, input logic [31:0] pcv,
                        input logic [15:0] k);
      exp_t e;
      logic [31:0] st;
      st = sz ? 32'd4 : 32'd1;
      e.we = 1'b0; e.wd = 'x; e.ia = 1'b1; e.due = 0;
      @(negedge clk);
      reg_direct = rd; mode = m; size_word = sz; reg_val = rv; pc = pcv; konst = k;
      start = 1'b1;
      if (rd) begin
         e.tag = "R2"; e.res = rv; e.ia = 1'b0;
      end else begin
         case (m)
            3'd0: begin e.tag = "R3"; e.res = sx(k); end
            3'd1: begin e.tag = "R4"; e.res = sx(k); e.ia = 1'b0; end
            3'd2: begin e.tag = "R5"; e.res = rv; end
            3'd3: begin e.tag = "R11"; e.res = memf(sx(k)); exp_ptr = sx(k); end
            3'd4: begin e.tag = "R6"; e.res = rv + sx(k); end
            3'd5: begin e.tag = "R7"; e.res = pcv + sx(k); end
            3'd6: begin e.tag = "R8"; e.res = rv; e.we = 1'b1; e.wd = rv + st; end
            default: begin e.tag = "R9"; e.res = rv - st; e.we = 1'b1; e.wd = rv - st; end
         endcase
      end
      e.due = (!rd && m == 3'd3) ? -1 : cyc + 1;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (!rd && m == 3'd3) begin
         while (busy) @(negedge clk);
      end
   endtask

   // memory responder with programmable latency
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rd_ready) begin
            mem_rd_ready = 1'b0;
         end else if (stray) begin
            mem_rd_ready = 1'b1;
            mem_rd_data  = 32'hDEAD_BEEF;
            stray = 1'b0;
         end else if (mem_rd_req) begin
            if (wait_cnt >= lat) begin
               check("R11", mem_rd_addr == exp_ptr, "pointer address", mem_rd_addr, exp_ptr);
               mem_rd_data  = memf(mem_rd_addr);
               mem_rd_ready = 1'b1;
               wait_cnt = 0;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   // monitor: pops and compares each result
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (wb_en && !done)
               check("R10", 1'b0, "write-back without result", 32'(wb_en), 32'd0);
            if (done) begin
               if (sb.size() == 0) begin
                  check("R12", 1'b0, "unexpected result", result, 32'd0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(e.tag, result == e.res, "result", result, e.res);
                  check(e.tag, is_addr == e.ia, "is_addr", 32'(is_addr), 32'(e.ia));
                  check("R10", wb_en == e.we, {e.tag, " wb_en"}, 32'(wb_en), 32'(e.we));
                  if (e.we)
                     check(e.tag, wb_data == e.wd, "wb_data", wb_data, e.wd);
                  if (e.due >= 0)
                     check("R13", cyc == e.due, {e.tag, " latency"}, 32'(cyc), 32'(e.due));
                  else
                     check("R11", prev_ready, "done one cycle after ready", 32'(prev_ready), 32'd1);
               end
            end
         end
         prev_ready = mem_rd_ready;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      check("WDOG", 1'b0, "watchdog expired", 32'(cyc), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", !busy && !done && !wb_en && !mem_rd_req, "reset outputs",
            {28'd0, busy, done, wb_en, mem_rd_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(1'b1, 3'd6, 1'b1, 32'h1234_5678, 32'h0, 16'h0010); // R2, mode ignored
      issue(1'b1, 3'd3, 1'b0, 32'hCAFE_0001, 32'h0, 16'h0100); // R2, no memory read
      issue(1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 16'h8000);         // R3, negative
      issue(1'b0, 3'd0, 1'b0, 32'h0, 32'h0, 16'h7FFF);         // R3
      issue(1'b0, 3'd1, 1'b0, 32'h0, 32'h0, 16'hFFFE);         // R4
      issue(1'b0, 3'd2, 1'b0, 32'h0000_4000, 32'h0, 16'h5555); // R5
      issue(1'b0, 3'd4, 1'b0, 32'hFFFF_FFF0, 32'h0, 16'h0020); // R6 wrap
      issue(1'b0, 3'd4, 1'b0, 32'h0000_1000, 32'h0, 16'hFFF0); // R6 negative
      issue(1'b0, 3'd5, 1'b0, 32'h9999_9999, 32'h0000_2000, 16'h0040); // R7
      issue(1'b0, 3'd5, 1'b0, 32'h0, 32'h0000_0010, 16'hFFE0); // R7 backwards
      issue(1'b0, 3'd6, 1'b1, 32'h0000_0100, 32'h0, 16'h0);    // R8 word
      issue(1'b0, 3'd6, 1'b0, 32'hFFFF_FFFF, 32'h0, 16'h0);    // R8 byte wrap
      issue(1'b0, 3'd7, 1'b1, 32'h0000_0000, 32'h0, 16'h0);    // R9 word wrap
      issue(1'b0, 3'd7, 1'b0, 32'h0000_0200, 32'h0, 16'h0);    // R9 byte
      lat = 0;
      issue(1'b0, 3'd3, 1'b0, 32'h0, 32'h0, 16'h0400);         // R11 no wait
      lat = 3;
      issue(1'b0, 3'd3, 1'b1, 32'h0, 32'h0, 16'hFF00);         // R11 waits
      issue(1'b0, 3'd2, 1'b0, 32'h0000_0ABC, 32'h0, 16'h0);    // R5 after fetch

      // R12: start while busy is ignored
      lat = 6;
      @(negedge clk);
      reg_direct = 1'b0; mode = 3'd3; konst = 16'h0123; start = 1'b1;
      begin
         exp_t e;
         e.tag = "R11"; e.res = memf(sx(16'h0123)); e.ia = 1'b1; e.we = 1'b0;
         e.wd = 'x; e.due = -1;
         exp_ptr = sx(16'h0123);
         sb.push_back(e);
      end
      @(negedge clk);
      mode = 3'd0; konst = 16'h0777;   // stays asserted while busy
      check("R12", busy, "busy during fetch", 32'(busy), 32'd1);
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);

      // R12: stray ready with nothing outstanding
      stray = 1'b1;
      repeat (4) @(negedge clk);
      check("R12", !done && !mem_rd_req, "no result from stray ready",
            {30'd0, done, mem_rd_req}, 32'd0);
      check("R10", !wb_en, "idle write-back", 32'(wb_en), 32'd0);

      // back-to-back mix
      issue(1'b0, 3'd6, 1'b1, 32'h0000_0FFC, 32'h0, 16'h0);    // R8
      issue(1'b0, 3'd1, 1'b0, 32'h0, 32'h0, 16'h0001);         // R4
      repeat (3) @(negedge clk);
      check("R13", sb.size() == 0, "all results received", 32'(sb.size()), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule